// File: doc/BRIEF.md
# Mode-Dependent Effective Address Generator

This block forms the storage operand address for an instruction. It adds a 64-bit base value, a 64-bit index value and an unsigned 12-bit displacement as one full-width 64-bit sum. It then clears the upper bits of that sum according to the addressing mode in force. The addressing mode is a 2-bit state register inside the block. Three mode modes exist: 24-bit, 31-bit and 64-bit.

The same command port carries four operations, selected by a 3-bit opcode:
- **Generate** (0) produces an address.
- **Set-mode** (1) loads the mode from a 2-bit selector without branching.
- **Branch-set-mode** (2) takes the new mode from two bits of a register operand. It also hands back a link value built from a return address.
- **Test-mode** (3) returns the current mode as a condition code.

Every result is registered. Each result comes with a one-cycle valid pulse on the clock edge after the command.

Top module: `amode_agen`

## Requirements
- R1: On a generate command (opcode 0), `addr_out` holds base + index + displacement on the next cycle, and `addr_valid` is high for that single cycle. The sum wraps modulo 2^64. The displacement is zero-extended. Base counts as zero when `base_en` is low, and index counts as zero when `index_en` is low.
- R2: The generated address is truncated by the mode in force when the command is taken. In 24-bit mode bits [63:24] are zero. In 31-bit mode bits [63:31] are zero. In 64-bit mode no bit is cleared.
- R3: `mode_out` encodes 24-bit mode as 2'b00, 31-bit mode as 2'b01 and 64-bit mode as 2'b11, so bit 0 stays set in 64-bit mode. The value 2'b10 never appears, and reset leaves 2'b00.
- R4: A test-mode command (opcode 3) gives `cc_out` = 0 for 24-bit mode, 1 for 31-bit mode and 3 for 64-bit mode on the next cycle, with `cc_valid` high for that one cycle.
- R5: A set-mode command (opcode 1) loads `mode_sel` into the mode register on the next edge when `mode_sel` is 00, 01 or 11. A `mode_sel` of 10 leaves the mode unchanged.
- R6: A branch-set-mode command (opcode 2) selects the new mode from `br_reg` (LSB-0 numbering). If bit [0] is 1, the new mode is 64-bit. If bit [0] is 0 and bit [31] is 1, the new mode is 31-bit. If both bits are 0, the new mode is 24-bit.
- R7: A branch-set-mode command drives `link_out` on the next cycle, with `link_valid` high for one cycle. `link_out` is `ret_addr` truncated by the mode in force before the switch, as in R2. In 64-bit mode bit [0] of `link_out` is forced to 1.
- R8: Opcodes 4 to 7, and any cycle with `cmd_valid` low, raise no valid strobe and leave the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 0 generate, 1 set-mode, 2 branch-set-mode, 3 test-mode |
| base_val | input | 64 | Base operand |
| base_en | input | 1 | Base operand present |
| index_val | input | 64 | Index operand |
| index_en | input | 1 | Index operand present |
| disp | input | 12 | Unsigned displacement |
| mode_sel | input | 2 | Target mode for set-mode |
| br_reg | input | 64 | Register operand for branch-set-mode |
| ret_addr | input | 64 | Return address for the link value |
| addr_out | output | 64 | Registered effective address |
| addr_valid | output | 1 | One-cycle pulse with a new address |
| mode_out | output | 2 | Current addressing mode |
| cc_out | output | 2 | Condition code from test-mode |
| cc_valid | output | 1 | One-cycle pulse with a new condition code |
| link_out | output | 64 | Link value from branch-set-mode |
| link_valid | output | 1 | One-cycle pulse with a new link value |

## Verification

The assertions check these properties on every cycle:
- The truncation limits that apply to each mode.
- The absence of the illegal mode code.
- The match between each condition code and the mode.
- That a rejected selector or an idle cycle leaves the mode untouched.
- That a link produced in 64-bit mode carries its low bit set.

Only the bench's scenarios can show the following:
- The actual sum values, including wraparound and the operand enables.
- The exact mode chosen from each combination of the two register bits.
- That each result uses the mode from before, not after, a switch in the neighbouring cycle.

// File: rtl/amode_pkg.sv
package amode_pkg;
  localparam int ADDR_W = 64;
  localparam int LIM24  = 24;
  localparam int LIM31  = 31;

  localparam logic [1:0] AM24 = 2'b00;
  localparam logic [1:0] AM31 = 2'b01;
  localparam logic [1:0] AM64 = 2'b11;

  typedef enum logic [2:0] {
    OP_GEN  = 3'd0,
    OP_SET  = 3'd1,
    OP_BSM  = 3'd2,
    OP_TEST = 3'd3
  } agen_op_t;

  // Clear upper bits according to the mode.
  function automatic logic [ADDR_W-1:0] trunc_by_mode(input logic [ADDR_W-1:0] a,
                                                      input logic [1:0] m);
    logic [ADDR_W-1:0] r;
    r = a;
    if (!m[0])      r[ADDR_W-1:LIM24] = '0;
    else if (!m[1]) r[ADDR_W-1:LIM31] = '0;
    return r;
  endfunction

  // Mode chosen from the register operand of a branch-set-mode.
  function automatic logic [1:0] mode_from_reg(input logic [ADDR_W-1:0] r);
    if (r[0])       return AM64;
    else if (r[31]) return AM31;
    else            return AM24;
  endfunction

  // Condition code reported for a mode.
  function automatic logic [1:0] cc_of_mode(input logic [1:0] m);
    case (m)
      AM31:    return 2'd1;
      AM64:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic mode_code_ok(input logic [1:0] m);
    return (m != 2'b10);
  endfunction
endpackage

// File: rtl/agen_sum.sv
module agen_sum
  import amode_pkg::*;
#(
  parameter int DISP_W = 12
) (
  input  logic [ADDR_W-1:0] base_val,
  input  logic              base_en,
  input  logic [ADDR_W-1:0] index_val,
  input  logic              index_en,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] ea
);
  localparam int PAD_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] b_op, x_op, d_op, raw;

  always_comb begin
    b_op = base_en  ? base_val  : '0;
    x_op = index_en ? index_val : '0;
    d_op = {{PAD_W{1'b0}}, disp};
    raw  = b_op + x_op + d_op;
    ea   = trunc_by_mode(raw, mode);
  end
endmodule

// File: rtl/amode_ctl.sv
module amode_ctl
  import amode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_stb,
  input  logic [1:0]        set_sel,
  input  logic              bsm_stb,
  input  logic [ADDR_W-1:0] bsm_reg,
  output logic [1:0]        mode_q,
  output logic              set_reject
);
  logic [1:0] mode_d;

  assign set_reject = set_stb && !mode_code_ok(set_sel);

  always_comb begin
    mode_d = mode_q;
    if (set_stb && !set_reject) mode_d = set_sel;
    else if (bsm_stb)           mode_d = mode_from_reg(bsm_reg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= AM24;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/amode_agen.sv
module amode_agen
  import amode_pkg::*;
#(
  parameter int DISP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [63:0]       base_val,
  input  logic              base_en,
  input  logic [63:0]       index_val,
  input  logic              index_en,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        mode_sel,
  input  logic [63:0]       br_reg,
  input  logic [63:0]       ret_addr,
  output logic [63:0]       addr_out,
  output logic              addr_valid,
  output logic [1:0]        mode_out,
  output logic [1:0]        cc_out,
  output logic              cc_valid,
  output logic [63:0]       link_out,
  output logic              link_valid
);
  logic gen_stb, set_stb, bsm_stb, test_stb, set_reject;
  logic [1:0]        mode_q;
  logic [ADDR_W-1:0] ea, link_d;

  assign gen_stb  = cmd_valid && (cmd_op == OP_GEN);
  assign set_stb  = cmd_valid && (cmd_op == OP_SET);
  assign bsm_stb  = cmd_valid && (cmd_op == OP_BSM);
  assign test_stb = cmd_valid && (cmd_op == OP_TEST);

  agen_sum #(.DISP_W(DISP_W)) u_sum (
    .base_val (base_val),
    .base_en  (base_en),
    .index_val(index_val),
    .index_en (index_en),
    .disp     (disp),
    .mode     (mode_q),
    .ea       (ea)
  );

  amode_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_stb   (set_stb),
    .set_sel   (mode_sel),
    .bsm_stb   (bsm_stb),
    .bsm_reg   (br_reg),
    .mode_q    (mode_q),
    .set_reject(set_reject)
  );

  always_comb begin
    link_d = trunc_by_mode(ret_addr, mode_q);
    if (mode_q == AM64) link_d[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
      cc_out     <= 2'd0;
      cc_valid   <= 1'b0;
      link_out   <= '0;
      link_valid <= 1'b0;
    end else begin
      addr_valid <= gen_stb;
      cc_valid   <= test_stb;
      link_valid <= bsm_stb;
      if (gen_stb)  addr_out <= ea;
      if (test_stb) cc_out   <= cc_of_mode(mode_q);
      if (bsm_stb)  link_out <= link_d;
    end
  end

  assign mode_out = mode_q;
endmodule

// File: rtl/amode_agen_chk.sv
module amode_agen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [63:0] addr_out,
  input logic        addr_valid,
  input logic [1:0]  mode_out,
  input logic [1:0]  cc_out,
  input logic        cc_valid,
  input logic [63:0] link_out,
  input logic        link_valid,
  input logic        set_reject
);
  p_trunc24_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && mode_out == 2'b00) |-> (addr_out[63:24] == '0));

  p_trunc31_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && mode_out == 2'b01) |-> (addr_out[63:31] == '0));

  p_mode_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_out != 2'b10);

  p_cc_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cc_valid |-> (cc_out == mode_out));

  p_reject_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_reject |=> $stable(mode_out));

  p_link_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && $past(mode_out) == 2'b11) |-> link_out[0]);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(mode_out) && !addr_valid && !cc_valid && !link_valid));

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({addr_valid, cc_valid, link_valid}) <= 1);
endmodule

bind amode_agen amode_agen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .addr_out  (addr_out),
  .addr_valid(addr_valid),
  .mode_out  (mode_out),
  .cc_out    (cc_out),
  .cc_valid  (cc_valid),
  .link_out  (link_out),
  .link_valid(link_valid),
  .set_reject(set_reject)
);

// File: tb/amode_agen_test.sv
module amode_agen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [63:0] base_val = '0, index_val = '0, br_reg = '0, ret_addr = '0;
  logic        base_en = 1'b0, index_en = 1'b0;
  logic [11:0] disp = '0;
  logic [1:0]  mode_sel = '0;
  logic [63:0] addr_out, link_out;
  logic        addr_valid, cc_valid, link_valid;
  logic [1:0]  mode_out, cc_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int          m_mode = 0;     // 0:24-bit, 1:31-bit, 3:64-bit
  bit          e_av, e_cv, e_lv;
  logic [63:0] e_addr, e_link;
  int          e_cc;

  always #2 clk = ~clk;  // 250 MHz

  amode_agen uut (.*);

  function automatic logic [63:0] cut(input logic [63:0] a, input int m);
    if (m == 0) return (a << 40) >> 40;
    if (m == 1) return (a << 33) >> 33;
    return a;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    check(mode_out == 2'(m_mode), "R3/R5/R6 mode", 64'(mode_out), 64'(m_mode));
    check(addr_valid == e_av, "R1/R8 addr_valid", 64'(addr_valid), 64'(e_av));
    if (e_av) check(addr_out == e_addr, "R1/R2 addr", addr_out, e_addr);
    check(cc_valid == e_cv, "R4/R8 cc_valid", 64'(cc_valid), 64'(e_cv));
    if (e_cv) check(cc_out == 2'(e_cc), "R4 cc", 64'(cc_out), 64'(e_cc));
    check(link_valid == e_lv, "R7/R8 link_valid", 64'(link_valid), 64'(e_lv));
    if (e_lv) check(link_out == e_link, "R7 link", link_out, e_link);
  endtask

  // drive one cycle at the falling edge; compare at the next falling edge
  task automatic cyc(input bit v, input int op, input logic [63:0] b, input bit be,
                     input logic [63:0] x, input bit xe, input logic [11:0] d,
                     input int sel, input logic [63:0] br, input logic [63:0] ra);
    logic [63:0] s;
    cmd_valid = v; cmd_op = 3'(op); base_val = b; base_en = be;
    index_val = x; index_en = xe; disp = d; mode_sel = 2'(sel);
    br_reg = br; ret_addr = ra;
    e_av = v && op == 0; e_cv = v && op == 3; e_lv = v && op == 2;
    s = (be ? b : 64'd0) + (xe ? x : 64'd0) + 64'(d);
    e_addr = cut(s, m_mode);
    e_cc = (m_mode == 3) ? 3 : m_mode;
    e_link = cut(ra, m_mode);
    if (m_mode == 3) e_link = e_link | 64'd1;
    @(negedge clk);
    if (v && op == 1 && sel != 2) m_mode = sel;
    if (v && op == 2) m_mode = br[0] ? 3 : (br[31] ? 1 : 0);
    compare();
  endtask

  task automatic gen(input logic [63:0] b, input logic [63:0] x, input logic [11:0] d);
    cyc(1, 0, b, 1, x, 1, d, 0, 0, 0);
  endtask
  task automatic setm(input int s);
    cyc(1, 1, 0, 0, 0, 0, 0, s, 0, 0);
  endtask
  task automatic bsm(input logic [63:0] r, input logic [63:0] ra);
    cyc(1, 2, 0, 0, 0, 0, 0, 0, r, ra);
  endtask
  task automatic tst();
    cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    e_av = 0; e_cv = 0; e_lv = 0; e_addr = '0; e_link = '0; e_cc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare();  // R3 reset state: 24-bit mode, no strobes
    // R1/R2 24-bit truncation of a large sum
    gen(64'hFFFF_FFFF_F0F0_1234, 64'h0000_0001_0000_0010, 12'hFFF);
    tst();  // R4 cc 0
    // R5 set 31-bit
    setm(1);
    gen(64'h1234_5678_FFFF_FFF0, 64'h0, 12'h020);
    tst();  // R4 cc 1
    // R5 rejected selector 10
    setm(2);
    tst();
    // R5 set 64-bit, R1 wraparound
    setm(3);
    gen(64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 12'h001);
    tst();  // R4 cc 3
    // R1 operand enables low
    cyc(1, 0, 64'hDEAD_BEEF_0000_0000, 0, 64'h100, 1, 12'h004, 0, 0, 0);
    cyc(1, 0, 64'h8000, 1, 64'hFFFF_0000_0000_0000, 0, 12'h000, 0, 0, 0);
    // R7 link in 64-bit mode gets LSB; R6 bit31 set, bit0 clear -> 31-bit
    bsm(64'h0000_0000_8000_0000, 64'hABCD_0000_1234_5670);
    tst();
    // R7 link in 31-bit, R6 both clear -> 24-bit
    bsm(64'hFFFF_FFFF_7FFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE);
    tst();
    // R6 bit0 set wins over bit31 -> 64-bit, link truncated to 24 bits
    bsm(64'h0000_0000_8000_0001, 64'h0123_4567_89AB_CDEF);
    tst();
    // R8 undefined opcodes and idle cycles
    for (int k = 4; k < 8; k++) cyc(1, k, 64'h55, 1, 64'h66, 1, 12'h7, 1, 64'h1, 64'h9);
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 2, 0, 0, 0, 0, 0, 0, 64'h0, 0);
    // mixed random traffic, compared on every cycle
    for (int i = 0; i < 400; i++) begin
      logic [63:0] rb, rx, rr, rt;
      rb = {$urandom, $urandom}; rx = {$urandom, $urandom};
      rr = {$urandom, $urandom}; rt = {$urandom, $urandom};
      cyc(($urandom % 8) != 0, int'($urandom % 6), rb, $urandom % 2, rx, $urandom % 2,
          12'($urandom), int'($urandom % 4), rr, rt);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule